// File: doc/BRIEF.md
# Phased-Clock Timer with Prescaler

An 8-bit timer/counter for a small microcontroller core. It runs on a fast phase clock; four consecutive phase clocks (Q1, Q2, Q3, Q4) form one instruction cycle, and the block keeps its own phase counter and shows it on `phaseOut`. The count register either advances once per instruction cycle or counts edges on an external pin, and a programmable power-of-two prescaler can be placed in either path.

An 8-bit control register picks the count source, the active pin edge, whether the prescaler is used and the division ratio. The external signal, after the edge select and the optional prescaler, is sampled only on the Q2 and Q4 phases. That sampling sets the minimum pulse widths the pin has to meet.

The core can write and read the count register. A write holds off counting for two instruction cycles and clears the prescaler. When the counter wraps past its top value it gives a one-cycle overflow pulse. While the external source is selected, the pin's direction is forced to input.

Top module: `phase_timer`

## Requirements
- R1: Reset sets the control register to 0xFF. A write on `ctlWrEn` is read back on `ctlRdData`. Field layout: [7] wake-up disable, [6] pull-up disable (both only stored), [5] source select (1 = pin), [4] edge select (1 = falling), [3] prescaler bypass (1 = bypass, ratio 1:1), [2:0] ratio r.
- R2: The count register changes only on a CPU write or a count. Reset leaves it unchanged.
- R3: `phaseOut` is 0 during reset and then steps 0,1,2,3,0,… once per clock. The values 0..3 stand for Q1..Q4.
- R4: With the internal source and the prescaler bypassed, the count rises by one on each Q4 clock edge.
- R5: A write loads the value at that edge and clears the prescaler. The clock edges of the next two instruction cycles (8 clocks) produce no increment.
- R6: With the internal source and the prescaler in use, the count rises each time prescaler stage r turns on. Counting from a cleared prescaler, this happens after 2^r source ticks and then every 2^(r+1) ticks.
- R7: With the pin source, the edge-selected signal (or the prescaler output) is sampled on Q2 and Q4. The count changes only on those edges. A pin level held 2 clocks high and 2 clocks low is counted every time.
- R8: Edge select 0 counts rising pin edges and edge select 1 counts falling pin edges. The other edge has no effect.
- R9: With the pin source and the prescaler in use, the prescaler counts active pin edges with the same division as R6.
- R10: The count wraps from 0xFF to 0x00. `ovfPulse` is high for exactly the one clock in which 0x00 first appears.
- R11: `pinDirOut` (1 = input) equals `trisIn` when source select is 0, and is 1 when source select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four per instruction cycle |
| rstN | input | 1 | Active-low reset |
| extClkIn | input | 1 | External count pin |
| trisIn | input | 1 | Direction setting for the pin from the I/O control (1 = input) |
| pinDirOut | output | 1 | Effective pin direction after the override |
| cntWrEn | input | 1 | CPU write strobe for the count register |
| cntWrData | input | CNT_W | Value to load into the count register |
| cntRdData | output | CNT_W | Current count |
| ctlWrEn | input | 1 | CPU write strobe for the control register |
| ctlWrData | input | 8 | Value for the control register |
| ctlRdData | output | 8 | Control register contents |
| phaseOut | output | 2 | Current phase, 0..3 = Q1..Q4 |
| ovfPulse | output | 1 | One-clock pulse on wrap to zero |

## Verification
The bench uses the default 8-bit count and two-cycle inhibit. This keeps all eight prescaler ratios in range for both internal and pin sources, and a full wrap of the counter within a few thousand clocks. Narrow pin pulses are started at all four phase alignments to exercise the Q2/Q4 sampling. Every ratio is checked against its first-increment offset as well as its steady rate, and the clock-by-clock count after a write is compared against the two-cycle hold.

// File: rtl/phase_timer_pkg.sv
package phase_timer_pkg;
  localparam int CTL_W    = 8;
  localparam int RATIO_W  = 3;
  localparam int PRE_W    = 1 << RATIO_W;
  localparam int PH_W     = 2;
  localparam int NUM_PH   = 1 << PH_W;
  localparam int BIT_SRC  = 5;
  localparam int BIT_EDGE = 4;
  localparam int BIT_BYP  = 3;

  typedef struct packed {
    logic load;
    logic incr;
  } cnt_strobe_t;
endpackage

// File: rtl/phase_timer_ctrl.sv
module phase_timer_ctrl
  import phase_timer_pkg::*;
#(
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClkIn,
  input  logic             cntWrEn,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlReg,
  output logic [PH_W-1:0]  phase,
  output cnt_strobe_t      strb
);
  localparam int INH_LEN = INH_CYC * NUM_PH;
  localparam int INH_W   = $clog2(INH_LEN + 1);

  logic [PRE_W-1:0]   preCnt;
  logic [INH_W-1:0]   inhCnt;
  logic               pinPrev, syncLvl;
  logic               srcExt, edgeFall, preBypass;
  logic [RATIO_W-1:0] ratio;
  logic               pinLvl, isQ2, isQ4, sampleNow;
  logic               preTick, stageRise, preOut;
  logic               extTick, intTick, rawTick;
  logic [PRE_W-1:0]   lowMask, selMask;

  always_comb begin
    srcExt    = ctlReg[BIT_SRC];
    edgeFall  = ctlReg[BIT_EDGE];
    preBypass = ctlReg[BIT_BYP];
    ratio     = ctlReg[RATIO_W-1:0];
    pinLvl    = extClkIn ^ edgeFall;
    isQ2      = (phase == PH_W'(1));
    isQ4      = (phase == PH_W'(NUM_PH - 1));
    sampleNow = isQ2 | isQ4;
    preTick   = srcExt ? (pinLvl & ~pinPrev) : isQ4;
    lowMask   = (PRE_W'(1) << ratio) - PRE_W'(1);
    selMask   = {lowMask[PRE_W-2:0], 1'b1};
    stageRise = preTick && ((preCnt & selMask) == lowMask);
    preOut    = preBypass ? pinLvl : preCnt[ratio];
    extTick   = sampleNow && preOut && !syncLvl;
    intTick   = isQ4 && (preBypass || stageRise);
    rawTick   = srcExt ? extTick : intTick;
    strb.load = rstN && cntWrEn;
    strb.incr = rstN && !cntWrEn && rawTick && (inhCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      ctlReg  <= '1;
      preCnt  <= '0;
      inhCnt  <= '0;
      pinPrev <= 1'b1;
      syncLvl <= 1'b1;
    end else begin
      phase   <= phase + PH_W'(1);
      pinPrev <= pinLvl;
      if (ctlWrEn) ctlReg <= ctlWrData;
      if (sampleNow) syncLvl <= preOut;
      if (cntWrEn) preCnt <= '0;
      else if (preTick) preCnt <= preCnt + PRE_W'(1);
      if (cntWrEn) inhCnt <= INH_W'(INH_LEN);
      else if (inhCnt != '0) inhCnt <= inhCnt - INH_W'(1);
    end
  end

  AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ctlReg == {CTL_W{1'b1}}); // R1
  AST_SAMPLE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |-> phase[0]); // R7
endmodule

// File: rtl/phase_timer_dp.sv
module phase_timer_dp
  import phase_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (strb.load) cnt <= wrData;
    else if (strb.incr) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovf <= 1'b0;
    else ovf <= strb.incr && !strb.load && (cnt == {CNT_W{1'b1}});
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> cnt == $past(cnt) + CNT_W'(1)); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incr && !strb.load |=> $stable(cnt)); // R2
  AST_WRITE_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) && !strb.load |=> $stable(cnt)); // R5
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> cnt == '0); // R10
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !ovf); // R10
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import phase_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClkIn,
  input  logic             trisIn,
  output logic             pinDirOut,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntRdData,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlRdData,
  output logic [PH_W-1:0]  phaseOut,
  output logic             ovfPulse
);
  cnt_strobe_t strb;

  phase_timer_ctrl #(.INH_CYC(INH_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn), .cntWrEn(cntWrEn),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlReg(ctlRdData),
    .phase(phaseOut), .strb(strb)
  );

  phase_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cntWrData),
    .cnt(cntRdData), .ovf(ovfPulse)
  );

  assign pinDirOut = trisIn | ctlRdData[BIT_SRC];
endmodule

// File: tb/phase_timer_tb_top.sv
`timescale 1ns/1ps
module phase_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClkIn = 1'b0, trisIn = 1'b0;
  logic       cntWrEn = 1'b0, ctlWrEn = 1'b0;
  logic [7:0] cntWrData = '0, ctlWrData = '0;
  logic       pinDirOut, ovfPulse;
  logic [7:0] cntRdData, ctlRdData;
  logic [1:0] phaseOut;
  int checks = 0, fails = 0;
  logic [7:0] prevCnt;

  always #2 clk = ~clk;

  phase_timer dut_i (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn), .trisIn(trisIn),
    .pinDirOut(pinDirOut), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntRdData(cntRdData), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .phaseOut(phaseOut), .ovfPulse(ovfPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCnt(input logic [7:0] v);
    while (phaseOut != 2'd3) @(negedge clk);
    cntWrEn = 1'b1; cntWrData = v;
    @(negedge clk);
    cntWrEn = 1'b0;
  endtask

  task automatic writeCtl(input logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic step(input bit watch);
    @(negedge clk);
    if (watch && cntRdData != prevCnt) chk("R7 change on Q2/Q4 edge", int'(phaseOut[0]), 0);
    prevCnt = cntRdData;
  endtask

  task automatic pulses(input int n, input bit watch);
    for (int i = 0; i < n; i++) begin
      extClkIn = 1'b1; step(watch); step(watch);
      extClkIn = 1'b0; step(watch); step(watch);
    end
  endtask

  initial begin
    tick(4);
    // R3 / R1: state during reset
    chk("R3 phase in reset", phaseOut, 0);
    chk("R1 ctl reset", ctlRdData, 8'hFF);
    rstN = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      chk("R3 phase sequence", phaseOut, n % 4);
    end
    chk("R11 override with pin source", pinDirOut, 1);
    // R2: count survives reset
    writeCnt(8'h5A);
    tick(12);
    chk("R2 written value holds", cntRdData, 8'h5A);
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(1);
    chk("R2 count kept over reset", cntRdData, 8'h5A);
    chk("R1 ctl reset again", ctlRdData, 8'hFF);
    // R1 readback and R11 direction
    writeCtl(8'hA5);
    chk("R1 readback", ctlRdData, 8'hA5);
    chk("R11 forced input", pinDirOut, 1);
    writeCtl(8'h00);
    chk("R11 follows tris 0", pinDirOut, 0);
    trisIn = 1'b1; tick(1);
    chk("R11 follows tris 1", pinDirOut, 1);
    trisIn = 1'b0;
    // R4 / R5: internal source, bypass
    writeCtl(8'h08);
    writeCnt(8'h10);
    chk("R5 written value", cntRdData, 8'h10);
    for (int n = 1; n <= 20; n++) begin
      int inc;
      @(negedge clk);
      inc = (n / 4) - 2;
      if (inc < 0) inc = 0;
      chk("R4/R5 count after write", cntRdData, (8'h10 + inc) & 8'hFF);
    end
    // R10: wrap and overflow pulse
    writeCnt(8'hFE);
    for (int n = 1; n <= 20; n++) begin
      int inc;
      @(negedge clk);
      inc = (n / 4) - 2;
      if (inc < 0) inc = 0;
      chk("R10 wrap value", cntRdData, (8'hFE + inc) & 8'hFF);
      chk("R10 overflow pulse", ovfPulse, (n == 16) ? 1 : 0);
    end
    // R6: internal source, prescaler swept over all ratios
    for (int r = 0; r < 8; r++) begin
      int m;
      writeCtl(8'(r));
      writeCnt(8'h00);
      m = 5 << r;
      tick(4 * m);
      chk("R6 first increments", cntRdData, (r <= 1) ? 2 : 3);
      tick(4 * (4 << r));
      chk("R6 steady rate", cntRdData, (r <= 1) ? 4 : 5);
    end
    // R7: pin source, bypass, rising edge, every phase alignment
    writeCtl(8'h28);
    tick(4);
    writeCnt(8'h00);
    tick(12);
    prevCnt = cntRdData;
    for (int o = 0; o < 4; o++) begin
      tick(o);
      prevCnt = cntRdData;
      pulses(5, 1'b1);
      tick(4);
      chk("R7 narrow pulses counted", cntRdData, 5 * (o + 1));
    end
    // R8: falling edge select
    writeCtl(8'h38);
    tick(4);
    writeCnt(8'h00);
    tick(12);
    for (int k = 0; k < 3; k++) begin
      extClkIn = 1'b1; tick(8);
      chk("R8 rising edge ignored", cntRdData, k);
      extClkIn = 1'b0; tick(8);
      chk("R8 falling edge counted", cntRdData, k + 1);
    end
    // R9: pin source through prescaler, all ratios
    for (int r = 0; r < 8; r++) begin
      writeCtl(8'h20 | 8'(r));
      tick(4);
      writeCnt(8'h00);
      tick(12);
      pulses((r + 3) << r, 1'b0);
      tick(8);
      chk("R9 prescaled pin count", cntRdData, (r + 4) / 2);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule